// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Byte Mapper

This block sits after a Reed-Solomon error locator that works on 12-bit symbols. It receives up to four (symbol position, 12-bit error pattern) pairs for one page and applies each pattern to a byte-wide page buffer. The buffer holds 2048 data bytes, and the spare area starts at buffer address 2048. Each 12-bit symbol straddles byte boundaries, so every position becomes one or two byte updates. Each update is a read-modify-write of an external synchronous RAM that has one cycle of read latency.

Before it writes anything, the block checks every pair. If any pair cannot be applied, the page is declared uncorrectable: nothing is written, and a fail flag is held until the next request. Otherwise the pairs are applied in slot order, and the number of corrected symbols is reported with a one-cycle done pulse. A separate combinational path splits the packed syndrome words coming from the decoder into eight 12-bit syndromes, two per 32-bit word.

Top module: `rs_sym_fixer`

## Requirements
- R1: A position above 1374 in any active slot makes the page uncorrectable: `fail` rises with `done`, and no RAM write occurs.
- R2: Position 0 touches only byte 0, which is XORed with pattern bits 7:0. If any of pattern bits 11:8 is set, the page is uncorrectable.
- R3: For an odd position p, byte floor(3p/2) is XORed with pattern bits 11:4, and the next byte is XORed with pattern bits 3:0 placed in bits 7:4.
- R4: For an even position p of 2 or more, byte 3p/2-1 is XORed with pattern bits 11:8 placed in bits 3:0, and byte 3p/2 is XORed with pattern bits 7:0.
- R5: Position 1365 is split across the area boundary: its upper 8 bits go to data byte 2047, and its low nibble goes to the upper half of spare byte 0 (buffer address 2048).
- R6: Positions 1366 to 1374 follow the same odd/even rules and land in the spare area. For example, 1367 touches addresses 2050 and 2051, and 1374 touches 2060 and 2061.
- R7: Syndrome word k supplies syndrome 2k from bits 11:0 and syndrome 2k+1 from bits 27:16. Syndrome j appears on `syn_out[12j+11:12j]`, and the other bits of the word are ignored.
- R8: When `ecc_flag` is low at the request, no write occurs, and `done` comes with `fix_cnt` = 0 and `fail` = 0.
- R9: A count above four in `err_cnt` makes the page uncorrectable.
- R10: On failure, all corrections of the page are discarded, even those of valid slots. `fix_cnt` is 0, and `fail` stays high until the next accepted request.
- R11: Each byte update takes a read cycle, then a write cycle to the same address. `done` is a one-cycle pulse that rises 1+2B cycles after the request edge, where B is the number of byte updates. On success, `fix_cnt` equals `err_cnt`.
- R12: Updates are applied in slot order and one at a time, so two symbols that touch the same byte both take effect.
- R13: Slots at or above `err_cnt` are ignored, even when they hold invalid values. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to process one page's pairs |
| ecc_flag | input | 1 | Decoder reported an error; correction enabled |
| err_cnt | input | 3 | Number of active pairs |
| err_pos | input | 44 | Four 11-bit symbol positions, slot i at bits 11i+10:11i |
| err_pat | input | 48 | Four 12-bit patterns, slot i at bits 12i+11:12i |
| syn_words | input | 128 | Four packed syndrome words |
| syn_out | output | 96 | Eight unpacked 12-bit syndromes |
| mem_addr | output | 12 | Page buffer byte address |
| mem_we | output | 1 | Page buffer write enable |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Byte read, valid the cycle after the address |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Page uncorrectable, held until next request |
| fix_cnt | output | 3 | Corrected symbol count |

## Verification
The hardest case to reach is a page where a valid pair would be written, but a later slot carries an illegal position or an oversized pattern at position 0. The check must show that even the valid bytes were left untouched. The stimulus places a legal correction in slot 0 and the offending value in a later active slot. It also places garbage in slots beyond the count, to show those are skipped. Overlapping symbols on a shared byte are driven back to back, so that a write and the next read of the same address fall on adjacent cycles.

// File: rtl/rsm_pkg.sv
// Shared constants and types for the symbol correction byte mapper.
// Assumes 12-bit symbols and an 8-bit page buffer with the spare area
// placed directly after the data area.
package rsm_pkg;
    localparam int SYM_W   = 12;
    localparam int BYTE_W  = 8;
    localparam int MAX_POS = 1374;
    localparam int POS_W   = $clog2(MAX_POS + 1);
    localparam int ADDR_W  = $clog2((3 * MAX_POS) / 2 + 2);

    // One symbol's effect on the buffer: up to two byte XOR updates.
    typedef struct packed {
        logic [ADDR_W-1:0] addr0;
        logic [ADDR_W-1:0] addr1;
        logic [BYTE_W-1:0] mask0;
        logic [BYTE_W-1:0] mask1;
        logic              pair;
        logic              bad;
    } byte_op_t;

    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_READ, ST_WRITE} seq_st_t;
endpackage

// File: rtl/rsm_syn_unpack.sv
// Splits packed syndrome words into 12-bit syndromes, two per word.
// Low syndrome from bits 11:0, high one from bits 27:16; the rest is unused.
module rsm_syn_unpack
    import rsm_pkg::*;
#(
    parameter int SYN_WORDS = 4
) (
    input  logic [32*SYN_WORDS-1:0]      syn_words,
    output logic [2*SYM_W*SYN_WORDS-1:0] syn_out
);
    logic [SYN_WORDS-1:0] unused_bits;

    for (genvar k = 0; k < SYN_WORDS; k++) begin : g_word
        assign syn_out[(2*k)*SYM_W +: SYM_W]   = syn_words[32*k +: SYM_W];
        assign syn_out[(2*k+1)*SYM_W +: SYM_W] = syn_words[32*k+16 +: SYM_W];
        assign unused_bits[k] = ^{syn_words[32*k+12 +: 4], syn_words[32*k+28 +: 4]};
    end
endmodule

// File: rtl/rsm_pos_map.sv
// Converts one (position, pattern) pair into byte addresses and XOR masks.
// Addressing is unified: spare bytes continue after data byte 2047, so the
// split symbol and spare-area symbols need no separate path.
module rsm_pos_map
    import rsm_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic [SYM_W-1:0] pat,
    output byte_op_t         op
);
    logic [POS_W+1:0]  trip;
    logic [ADDR_W-1:0] half;
    logic              unused_lsb;

    assign trip       = {2'b00, pos} + {1'b0, pos, 1'b0};
    assign half       = ADDR_W'(trip >> 1);
    assign unused_lsb = trip[0];

    // Select alignment rule: zero, odd or even position.
    always_comb begin
        op.bad = (int'(pos) > MAX_POS);
        if (pos == '0) begin
            op.addr0 = '0;
            op.addr1 = '0;
            op.mask0 = pat[7:0];
            op.mask1 = '0;
            op.pair  = 1'b0;
            op.bad   = op.bad | (pat[11:8] != 4'h0);
        end else if (pos[0]) begin
            op.addr0 = half;
            op.addr1 = half + ADDR_W'(1);
            op.mask0 = pat[11:4];
            op.mask1 = {pat[3:0], 4'h0};
            op.pair  = 1'b1;
        end else begin
            op.addr0 = half - ADDR_W'(1);
            op.addr1 = half;
            op.mask0 = {4'h0, pat[11:8]};
            op.mask1 = pat[7:0];
            op.pair  = 1'b1;
        end
    end
endmodule

// File: rtl/rsm_seq.sv
// Sequencer: validates all active slots first, then performs two-cycle
// read-modify-write updates in slot order. Assumes RAM read data is valid
// one cycle after the address.
module rsm_seq
    import rsm_pkg::*;
#(
    parameter int NUM_ERR = 4,
    parameter int CNT_W   = $clog2(NUM_ERR + 1) + 1,
    parameter int IDX_W   = (NUM_ERR > 1) ? $clog2(NUM_ERR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ecc_flag,
    input  logic [CNT_W-1:0]  err_cnt,
    input  byte_op_t          ops [NUM_ERR],
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [CNT_W-1:0]  fix_cnt
);
    seq_st_t          state;
    logic [IDX_W-1:0] idx;
    logic             hi;
    logic [CNT_W-1:0] cnt_q;
    logic             gate_q;
    logic             reject;
    logic             last;
    byte_op_t         cur;

    // Page is rejected if the count is too large or any active slot is bad.
    always_comb begin
        reject = (cnt_q > CNT_W'(NUM_ERR));
        for (int i = 0; i < NUM_ERR; i++)
            if (CNT_W'(i) < cnt_q && ops[i].bad) reject = 1'b1;
    end

    // Current byte operation and RAM drive.
    always_comb begin
        cur       = ops[idx];
        last      = ((CNT_W'(idx) + CNT_W'(1)) == cnt_q);
        mem_addr  = hi ? cur.addr1 : cur.addr0;
        mem_we    = (state == ST_WRITE);
        mem_wdata = mem_rdata ^ (hi ? cur.mask1 : cur.mask0);
        busy      = (state != ST_IDLE);
    end

    // Main control: accept, check, then step through reads and writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            hi      <= 1'b0;
            cnt_q   <= '0;
            gate_q  <= 1'b0;
            done    <= 1'b0;
            fail    <= 1'b0;
            fix_cnt <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    cnt_q   <= err_cnt;
                    gate_q  <= ecc_flag;
                    fail    <= 1'b0;
                    fix_cnt <= '0;
                    idx     <= '0;
                    hi      <= 1'b0;
                    state   <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (reject) begin
                        fail  <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (!gate_q || cnt_q == '0) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_READ;
                    end
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    if (!hi && cur.pair) begin
                        hi    <= 1'b1;
                        state <= ST_READ;
                    end else if (last) begin
                        done    <= 1'b1;
                        fix_cnt <= cnt_q;
                        state   <= ST_IDLE;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        hi    <= 1'b0;
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rs_sym_fixer.sv
// Top: latches the error pairs on an accepted request, maps each to byte
// operations, and runs the read-modify-write sequencer. Syndrome unpacking
// is purely combinational and independent of the sequencer.
module rs_sym_fixer
    import rsm_pkg::*;
#(
    parameter int NUM_ERR   = 4,
    parameter int SYN_WORDS = 4,
    parameter int CNT_W     = $clog2(NUM_ERR + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         ecc_flag,
    input  logic [CNT_W-1:0]             err_cnt,
    input  logic [POS_W*NUM_ERR-1:0]     err_pos,
    input  logic [SYM_W*NUM_ERR-1:0]     err_pat,
    input  logic [32*SYN_WORDS-1:0]      syn_words,
    output logic [2*SYM_W*SYN_WORDS-1:0] syn_out,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic                         mem_we,
    output logic [BYTE_W-1:0]            mem_wdata,
    input  logic [BYTE_W-1:0]            mem_rdata,
    output logic                         busy,
    output logic                         done,
    output logic                         fail,
    output logic [CNT_W-1:0]             fix_cnt
);
    logic [POS_W-1:0] pos_q [NUM_ERR];
    logic [SYM_W-1:0] pat_q [NUM_ERR];
    byte_op_t         ops   [NUM_ERR];

    // Capture the pairs only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ERR; i++) begin
                pos_q[i] <= '0;
                pat_q[i] <= '0;
            end
        end else if (start && !busy) begin
            for (int i = 0; i < NUM_ERR; i++) begin
                pos_q[i] <= err_pos[POS_W*i +: POS_W];
                pat_q[i] <= err_pat[SYM_W*i +: SYM_W];
            end
        end
    end

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_map
        rsm_pos_map u_map (.pos(pos_q[g]), .pat(pat_q[g]), .op(ops[g]));
    end

    rsm_syn_unpack #(.SYN_WORDS(SYN_WORDS)) u_syn (
        .syn_words(syn_words),
        .syn_out  (syn_out)
    );

    rsm_seq #(.NUM_ERR(NUM_ERR), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ecc_flag (ecc_flag),
        .err_cnt  (err_cnt),
        .ops      (ops),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .busy     (busy),
        .done     (done),
        .fail     (fail),
        .fix_cnt  (fix_cnt)
    );
endmodule

// File: rtl/rsm_chk.sv
// Protocol checker for rs_sym_fixer, attached by bind.
// Assumes a synchronous active-low reset.
module rsm_chk
    import rsm_pkg::*;
#(
    parameter int NUM_ERR = 4,
    parameter int CNT_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [CNT_W-1:0]  fix_cnt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    // R11
    rmw_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr)) && !$past(mem_we));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    fail_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (fix_cnt == '0));
    // R10
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !mem_we);
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);
    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fix_cnt) <= NUM_ERR);
endmodule

bind rs_sym_fixer rsm_chk #(.NUM_ERR(NUM_ERR), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
    .fix_cnt(fix_cnt), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/rs_sym_fixer_tb.sv
`timescale 1ns/1ps
module rs_sym_fixer_tb;
    localparam int MEMSZ = 4096;
    localparam int SPAN  = 2070;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ecc_flag = 1'b0;
    logic [2:0]  err_cnt = '0;
    logic [43:0] err_pos = '0;
    logic [47:0] err_pat = '0;
    logic [127:0] syn_words = '0;
    logic [95:0] syn_out;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        busy, done, fail;
    logic [2:0]  fix_cnt;

    int errors = 0;
    int checks = 0;
    logic [7:0] ram [MEMSZ];
    logic [7:0] refm [MEMSZ];
    int qa[$];
    int qd[$];

    always #5 clk = ~clk;

    rs_sym_fixer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ecc_flag(ecc_flag),
        .err_cnt(err_cnt), .err_pos(err_pos), .err_pat(err_pat),
        .syn_words(syn_words), .syn_out(syn_out), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .fix_cnt(fix_cnt)
    );

    // Page buffer: synchronous RAM with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Every clock: each write must match the next expected update.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (qa.size() == 0) chk(1'b0, "R10 unexpected write", int'(mem_addr), -1);
            else begin
                chk(int'(mem_addr) == qa[0], "R11 write address", int'(mem_addr), qa[0]);
                chk(int'(mem_wdata) == qd[0], "R12 write data", int'(mem_wdata), qd[0]);
                void'(qa.pop_front());
                void'(qd.pop_front());
            end
        end
    end

    task automatic apply(input int a, input int m);
        refm[a] = refm[a] ^ 8'(m);
        qa.push_back(a);
        qd.push_back(int'(refm[a]));
    endtask

    // Reference: build expected updates from the requirements.
    task automatic run(input string tag, input int n, input bit gate,
                       input int p[4], input int t[4], input bit poke);
        bit efail;
        int ebytes;
        int cyc;
        efail = (n > 4);
        for (int i = 0; i < 4; i++)
            if (i < n && (p[i] > 1374 || (p[i] == 0 && t[i] > 255))) efail = 1'b1;
        if (!efail && gate) begin
            for (int i = 0; i < n; i++) begin
                if (p[i] == 0) apply(0, t[i] & 255);
                else if (p[i] % 2 == 1) begin
                    apply(3 * p[i] / 2, t[i] >> 4);
                    apply(3 * p[i] / 2 + 1, (t[i] & 15) << 4);
                end else begin
                    apply(3 * p[i] / 2 - 1, t[i] >> 8);
                    apply(3 * p[i] / 2, t[i] & 255);
                end
            end
        end
        ebytes = qa.size();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            err_pos[11*i +: 11] = 11'(p[i]);
            err_pat[12*i +: 12] = 12'(t[i]);
        end
        err_cnt = 3'(n);
        ecc_flag = gate;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 1000) begin
            if (poke && cyc == 0) begin
                start = 1'b1;
                err_cnt = 3'd4;
                err_pos = {4{11'd1400}};
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == 1 + 2 * ebytes, {tag, " R11 latency"}, cyc, 1 + 2 * ebytes);
        chk(fail == efail, {tag, " R10 fail flag"}, int'(fail), int'(efail));
        chk(int'(fix_cnt) == ((efail || !gate) ? 0 : n), {tag, " R11 count"},
            int'(fix_cnt), (efail || !gate) ? 0 : n);
        chk(qa.size() == 0, {tag, " R12 missing writes"}, qa.size(), 0);
        qa.delete();
        qd.delete();
        begin
            int bad = 0;
            for (int a = 0; a < SPAN; a++) if (ram[a] !== refm[a]) bad++;
            chk(bad == 0, {tag, " buffer contents"}, bad, 0);
        end
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < MEMSZ; a++) begin
            ram[a] = 8'((a * 7 + 3) & 255);
            refm[a] = ram[a];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && fix_cnt == 0, "reset state", int'(busy), 0);
        chk(!mem_we, "reset no write", int'(mem_we), 0);

        // R7: syndrome unpacking with garbage in ignored nibbles
        for (int k = 0; k < 4; k++)
            syn_words[32*k +: 32] = {4'hF, 12'(300 + 2*k + 1), 4'hE, 12'(300 + 2*k)};
        #1;
        for (int j = 0; j < 8; j++)
            chk(int'(syn_out[12*j +: 12]) == 300 + j, "R7 syndrome", int'(syn_out[12*j +: 12]), 300 + j);

        run("R3 odd", 1, 1'b1, '{5, 0, 0, 0}, '{12'hABC, 0, 0, 0}, 1'b0);
        run("R4 even", 1, 1'b1, '{4, 0, 0, 0}, '{12'h5A3, 0, 0, 0}, 1'b0);
        run("R2 zero ok", 1, 1'b1, '{0, 0, 0, 0}, '{12'h0A5, 0, 0, 0}, 1'b0);
        run("R2 zero bad", 1, 1'b1, '{0, 0, 0, 0}, '{12'h1A5, 0, 0, 0}, 1'b0);
        run("R5 split", 1, 1'b1, '{1365, 0, 0, 0}, '{12'hF0F, 0, 0, 0}, 1'b0);
        run("R6 spare", 2, 1'b1, '{1374, 1367, 0, 0}, '{12'h123, 12'h456, 0, 0}, 1'b0);
        run("R12 overlap", 4, 1'b1, '{1, 2, 3, 1000}, '{12'hFFF, 12'h3C3, 12'h811, 12'h777}, 1'b0);
        run("R1 range", 2, 1'b1, '{7, 1375, 0, 0}, '{12'h111, 12'h222, 0, 0}, 1'b0);
        repeat (3) @(negedge clk);
        chk(fail == 1'b1, "R10 fail held", int'(fail), 1);
        run("R10 late bad", 3, 1'b1, '{9, 10, 0, 0}, '{12'h0F0, 12'h00F, 12'h300, 0}, 1'b0);
        run("R8 gate off", 2, 1'b0, '{9, 10, 0, 0}, '{12'h0F0, 12'h00F, 0, 0}, 1'b0);
        run("R9 too many", 5, 1'b1, '{9, 10, 11, 12}, '{1, 2, 3, 4}, 1'b0);
        run("R13 unused slots", 1, 1'b1, '{20, 2000, 0, 0}, '{12'h9C6, 12'hFFF, 12'hFFF, 0}, 1'b1);
        run("R11 zero count", 0, 1'b1, '{2000, 0, 0, 0}, '{0, 0, 0, 0}, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule